// File: doc/BRIEF.md
# Delayed Read Transaction Guard

This block keeps track of one inbound read that a bus bridge has turned into a delayed transaction, meaning the read was told to retry before its first data phase finished. While that read is outstanding, the guard tells the bridge to answer every other inbound request with a retry. A retry from the original master is recognised through a match indication, and it is let through. When the original master completes its read, the guard goes back to idle.

A master can stop retrying for good. If it does, the bridge would reject everyone else forever, which is a live-lock. To prevent this, the guard counts the requests it rejects. Once that count reaches a limit chosen by a 3-bit field, it drops the delayed entry and raises a one-cycle discard pulse. The limit is a power of two, and the all-zero code turns the limit off.

The bridge sets the delayed-read strobe in the cycle it retries the read. It gates its retry response with the reject output, which is combinational from the request inputs. It uses the discard pulse to free its own delayed-read resources.

Top module: `delayed_read_guard`

## Requirements
- R1: While reset is held and in the first cycle after it, `pending`, `rejectRetry` and `discardPulse` are all low.
- R2: When `delayStart` is high while idle, `pending` is high from the next cycle on. A `delayStart` while already pending has no effect.
- R3: `rejectRetry` is high in the same cycle as a request with `reqValid`=1 and `reqMatch`=0 while `pending` is high. No request is rejected while idle.
- R4: A request with `reqMatch`=1 is never rejected. It neither adds to the rejection count nor clears it.
- R5: `satisfyStrb` while pending makes `pending` low in the next cycle with no discard. This holds even when the same cycle carries a rejection that would reach the limit.
- R6: `limitCode` selects the limit L. Code 0 means no limit. Codes 1 to 7 give L = 2^code, so 1=2, 2=4, 3=8, 4=16, 5=32, 6=64 and 7=128. The L-th rejection is still rejected, and in the cycle after it `pending` is low and `discardPulse` is high.
- R7: `discardPulse` lasts exactly one cycle.
- R8: The rejection count restarts from zero after a satisfy or a discard, so the next delayed read again needs L rejections.
- R9: A `delayStart` in the cycle where `discardPulse` is high is accepted.
- R10: `limitCode` is read at each rejection. If the count already meets or exceeds a newly lowered limit, the next rejection discards. A raised limit extends the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| delayStart | input | 1 | An inbound read was just retried before its first data phase |
| reqValid | input | 1 | An inbound request is presented this cycle |
| reqMatch | input | 1 | The presented request is the original delayed read |
| satisfyStrb | input | 1 | The delayed read has completed |
| limitCode | input | 3 | Rejection limit code (0 = unlimited, else 2^code) |
| pending | output | 1 | A delayed read is outstanding |
| rejectRetry | output | 1 | Answer the current request with retry |
| discardPulse | output | 1 | One-cycle pulse: the delayed read was dropped |

## Verification
The assertions assume that `reqMatch` matters only when `reqValid` is high. They also assume that `limitCode` is held steady across the cycle in which a rejection is counted. The bench changes the code only between request cycles and drives all strobes at the falling edge. The properties also rely on the bridge never raising `satisfyStrb` for a read that is not pending. The bench does raise it in some idle cycles, but only in tests that check that nothing happens.

// File: rtl/delayed_read_guard_pkg.sv
package delayed_read_guard_pkg;

  typedef struct packed {
    logic incCount;
    logic clrCount;
  } ctlStrobes_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_PEND = 1'b1
  } guardState_t;

endpackage

// File: rtl/delayed_read_guard_datapath.sv
module delayed_read_guard_datapath
  import delayed_read_guard_pkg::*;
#(
  parameter int LIMIT_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobes_t        strobes,
  input  logic [LIMIT_W-1:0] limitCode,
  output logic               limitHit
);

  localparam int CNT_W = 2 ** LIMIT_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W:0]   ONE_WIDE = 1;

  logic [CNT_W-1:0] rejCount;
  logic [CNT_W:0]   nextCount;
  logic [CNT_W:0]   limitValue;

  // saturating rejection counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rejCount <= '0;
    end else if (strobes.clrCount) begin
      rejCount <= '0;
    end else if (strobes.incCount && (rejCount != CNT_MAX)) begin
      rejCount <= rejCount + 1'b1;
    end
  end

  always_comb begin
    nextCount  = {1'b0, rejCount} + ONE_WIDE;
    limitValue = ONE_WIDE << limitCode;
    limitHit   = (limitCode != '0) && (nextCount >= limitValue);
  end

endmodule

// File: rtl/delayed_read_guard_ctrl.sv
module delayed_read_guard_ctrl
  import delayed_read_guard_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        delayStart,
  input  logic        reqValid,
  input  logic        reqMatch,
  input  logic        satisfyStrb,
  input  logic        limitHit,
  output ctlStrobes_t strobes,
  output logic        pending,
  output logic        rejectRetry,
  output logic        discardPulse
);

  guardState_t state, stateNext;
  logic discardNow;

  always_comb begin
    pending     = (state == ST_PEND);
    rejectRetry = pending && reqValid && !reqMatch;
    discardNow  = rejectRetry && limitHit && !satisfyStrb;

    strobes.incCount = rejectRetry && !limitHit && !satisfyStrb;
    strobes.clrCount = !pending || satisfyStrb || discardNow;

    stateNext = state;
    unique case (state)
      ST_IDLE: if (delayStart) stateNext = ST_PEND;
      ST_PEND: if (satisfyStrb || discardNow) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      discardPulse <= 1'b0;
    end else begin
      state        <= stateNext;
      discardPulse <= discardNow;
    end
  end

endmodule

// File: rtl/delayed_read_guard.sv
module delayed_read_guard
  import delayed_read_guard_pkg::*;
#(
  parameter int LIMIT_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               delayStart,
  input  logic               reqValid,
  input  logic               reqMatch,
  input  logic               satisfyStrb,
  input  logic [LIMIT_W-1:0] limitCode,
  output logic               pending,
  output logic               rejectRetry,
  output logic               discardPulse
);

  ctlStrobes_t strobes;
  logic        limitHit;

  delayed_read_guard_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .delayStart   (delayStart),
    .reqValid     (reqValid),
    .reqMatch     (reqMatch),
    .satisfyStrb  (satisfyStrb),
    .limitHit     (limitHit),
    .strobes      (strobes),
    .pending      (pending),
    .rejectRetry  (rejectRetry),
    .discardPulse (discardPulse)
  );

  delayed_read_guard_datapath #(
    .LIMIT_W (LIMIT_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .limitCode (limitCode),
    .limitHit  (limitHit)
  );

endmodule

// File: rtl/delayed_read_guard_checker.sv
module delayed_read_guard_checker #(
  parameter int LIMIT_W = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic               delayStart,
  input logic               reqValid,
  input logic               reqMatch,
  input logic               satisfyStrb,
  input logic [LIMIT_W-1:0] limitCode,
  input logic               pending,
  input logic               rejectRetry,
  input logic               discardPulse
);

  assert_reject_needs_pending_R3: assert property (@(posedge clk) disable iff (!rstN)
    rejectRetry |-> pending);

  assert_match_not_rejected_R4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqMatch) |-> !rejectRetry);

  assert_start_sets_pending_R2: assert property (@(posedge clk) disable iff (!rstN)
    (delayStart && !pending) |=> pending);

  assert_satisfy_clears_R5: assert property (@(posedge clk) disable iff (!rstN)
    (satisfyStrb && pending) |=> (!pending && !discardPulse));

  assert_discard_one_cycle_R7: assert property (@(posedge clk) disable iff (!rstN)
    discardPulse |=> !discardPulse);

  assert_discard_after_reject_R6: assert property (@(posedge clk) disable iff (!rstN)
    discardPulse |-> ($past(rejectRetry) && $past(limitCode) != '0 && !pending));

endmodule

bind delayed_read_guard delayed_read_guard_checker #(.LIMIT_W(LIMIT_W)) u_checker (
  .clk          (clk),
  .rstN         (rstN),
  .delayStart   (delayStart),
  .reqValid     (reqValid),
  .reqMatch     (reqMatch),
  .satisfyStrb  (satisfyStrb),
  .limitCode    (limitCode),
  .pending      (pending),
  .rejectRetry  (rejectRetry),
  .discardPulse (discardPulse)
);

// File: tb/delayed_read_guard_bench.sv
`timescale 1ns/1ps
module delayed_read_guard_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       delayStart = 1'b0;
  logic       reqValid = 1'b0;
  logic       reqMatch = 1'b0;
  logic       satisfyStrb = 1'b0;
  logic [2:0] limitCode = 3'd0;
  logic       pending, rejectRetry, discardPulse;

  int checks = 0;
  int errors = 0;
  logic rejSeen;
  bit finished = 0;

  always #5 clk = ~clk;

  delayed_read_guard u_delayed_read_guard (
    .clk(clk), .rstN(rstN), .delayStart(delayStart), .reqValid(reqValid),
    .reqMatch(reqMatch), .satisfyStrb(satisfyStrb), .limitCode(limitCode),
    .pending(pending), .rejectRetry(rejectRetry), .discardPulse(discardPulse)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one cycle: drive at falling edge, sample reject mid-cycle, then step past the edge
  task automatic step(input logic v, input logic m, input logic st, input logic sat);
    @(negedge clk);
    reqValid = v; reqMatch = m; delayStart = st; satisfyStrb = sat;
    #1 rejSeen = rejectRetry;
    @(posedge clk);
    #1;
    reqValid = 0; reqMatch = 0; delayStart = 0; satisfyStrb = 0;
  endtask

  task automatic goIdle();
    step(0, 0, 0, 1);
    check("R5 idle after satisfy", pending, 0);
  endtask

  task automatic testReset();
    check("R1 pending in reset", pending, 0);
    check("R1 reject in reset", rejectRetry, 0);
    check("R1 discard in reset", discardPulse, 0);
    @(negedge clk) rstN = 1;
    @(posedge clk); #1;
    check("R1 pending after reset", pending, 0);
    check("R1 discard after reset", discardPulse, 0);
  endtask

  task automatic testStartAndIdle();
    limitCode = 3'd1;
    step(1, 0, 0, 0);
    check("R3 no reject while idle", rejSeen, 0);
    check("R3 idle stays idle", pending, 0);
    step(0, 0, 1, 0);
    check("R2 start sets pending", pending, 1);
    step(0, 0, 1, 0);
    check("R2 start while pending", pending, 1);
    check("R2 no discard from start", discardPulse, 0);
    step(1, 0, 0, 0);
    check("R3 reject while pending", rejSeen, 1);
    step(1, 0, 0, 0);
    check("R6 second reject at limit 2", rejSeen, 1);
    check("R6 pending dropped", pending, 0);
    check("R6 discard pulse", discardPulse, 1);
    step(0, 0, 1, 0);
    check("R7 discard one cycle", discardPulse, 0);
    check("R9 start during discard", pending, 1);
    goIdle();
  endtask

  task automatic testMatch();
    limitCode = 3'd1;
    step(0, 0, 1, 0);
    for (int i = 0; i < 5; i++) begin
      step(1, 1, 0, 0);
      check("R4 match not rejected", rejSeen, 0);
    end
    check("R4 matches not counted", discardPulse, 0);
    step(1, 0, 0, 0);
    check("R4 first reject no discard", discardPulse, 0);
    step(1, 1, 0, 0);
    step(1, 0, 0, 0);
    check("R4 match keeps count", discardPulse, 1);
    goIdle();
  endtask

  task automatic testSatisfy();
    limitCode = 3'd1;
    step(0, 0, 1, 0);
    step(1, 0, 0, 0);
    step(0, 0, 0, 1);
    check("R5 satisfy clears pending", pending, 0);
    check("R5 satisfy no discard", discardPulse, 0);
    step(0, 0, 1, 0);
    step(1, 0, 0, 0);
    check("R8 count restarted", discardPulse, 0);
    check("R8 still pending", pending, 1);
    step(1, 0, 0, 1);
    check("R5 reject shown with satisfy", rejSeen, 1);
    check("R5 satisfy beats discard", discardPulse, 0);
    check("R5 satisfy pending low", pending, 0);
  endtask

  task automatic runLimit(input logic [2:0] code);
    int lim;
    int early;
    lim = 1 << code;
    early = 0;
    limitCode = code;
    step(0, 0, 1, 0);
    for (int i = 1; i < lim; i++) begin
      step(1, 0, 0, 0);
      if (discardPulse) early++;
    end
    check($sformatf("R6 no early discard code %0d", code), early, 0);
    step(1, 0, 0, 0);
    check($sformatf("R6 discard at limit code %0d", code), discardPulse, 1);
    check($sformatf("R8 idle after discard code %0d", code), pending, 0);
  endtask

  task automatic testNoLimit();
    int drops;
    drops = 0;
    limitCode = 3'd0;
    step(0, 0, 1, 0);
    for (int i = 0; i < 300; i++) begin
      step(1, 0, 0, 0);
      if (discardPulse || !pending) drops++;
    end
    check("R6 code 0 never discards", drops, 0);
    goIdle();
  endtask

  task automatic testLimitChange();
    limitCode = 3'd7;
    step(0, 0, 1, 0);
    for (int i = 0; i < 5; i++) step(1, 0, 0, 0);
    check("R10 no discard at 5 of 128", discardPulse, 0);
    limitCode = 3'd1;
    step(1, 0, 0, 0);
    check("R10 lowered limit discards", discardPulse, 1);
    limitCode = 3'd1;
    step(0, 0, 1, 0);
    step(1, 0, 0, 0);
    limitCode = 3'd3;
    for (int i = 2; i < 8; i++) step(1, 0, 0, 0);
    check("R10 raised limit extends", discardPulse, 0);
    step(1, 0, 0, 0);
    check("R10 discard at raised limit", discardPulse, 1);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #12;
    testReset();
    testStartAndIdle();
    testMatch();
    testSatisfy();
    runLimit(3'd2);
    runLimit(3'd3);
    runLimit(3'd7);
    testNoLimit();
    testLimitChange();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule